// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block produces the partial-write byte enables for the two ends of a pixel span that is stored in 8-byte blocks. Software passes the address of the first element of the span and the address of the last element. For the first address the block derives a "left" mask: the lanes from that element to the end of its block. For the second address it derives a "right" mask: the lanes from the start of the block up to and including that element. When both addresses fall in the same 8-byte block, the span starts and ends there, and the result is the intersection of the two masks. Otherwise only the left mask is returned.

Three element widths are supported: 8, 16 and 32 bits, which give 8, 4 and 2 lanes. Either lane ordering can be selected, and a 32-bit addressing mode drops the upper address halves before the masks and the block comparison are computed. Most operation codes also record the condition flags of subtracting the second address from the first. The flags are kept for both a 32-bit and a 64-bit result, and the full addresses are always used for them. The result is registered: one cycle after a request it appears zero-extended on a 64-bit output, together with a one-cycle valid pulse.

Top module: `edge_mask_unit`

## Requirements
- R1: While reset is active and after it, until the first request, `res_valid`, `res_mask`, `cc_narrow` and `cc_wide` are all zero.
- R2: Each cycle in which `req_valid` is high yields `res_valid` high in the next cycle only. The result is `res_mask`, with bits 63:8 always zero.
- R3: `edge_op` encoding: bit 0 set means flags are not updated; bit 1 set selects little-endian lane order; bits 3:2 select the element size (00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = handled as 8-bit).
- R4: 8-bit elements use offset n = address bits 2:0. In big-endian order, left = 0xFF >> n and right has its n+1 upper bits set. In little-endian order, left = (0xFF << n) & 0xFF and right = (2^(n+1)) - 1. The masks appear in `res_mask` bits 7:0.
- R5: 16-bit elements use index m = address bits 2:1 and a mask in bits 3:0. In big-endian order, left = 0xF >> m and right has its m+1 upper bits set. In little-endian order, left = (0xF << m) & 0xF and right = (2^(m+1)) - 1.
- R6: 32-bit elements use address bit 2 and a mask in bits 1:0. In big-endian order, left is 3 then 1 and right is 2 then 3. In little-endian order, left is 3 then 2 and right is 1 then 3.
- R7: If the two addresses agree in every bit above bit 2, the result is left AND right, which may be zero. Otherwise the result is the left mask.
- R8: With `narrow_mode` high, both addresses are reduced to their low 32 bits before the mask lookup and the block comparison.
- R9: When `edge_op` bit 0 is clear, the flags of A minus B are registered with the result, using the full addresses in either mode. `cc_wide` holds the flags of the 64-bit result and `cc_narrow` those of the 32-bit result. Each is {N, Z, V, C} in bits 3 down to 0, where C is the borrow (A below B unsigned).
- R10: When `edge_op` bit 0 is set, or when no request is made, `cc_narrow` and `cc_wide` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one operation per high cycle |
| edge_op | input | 4 | Operation code: flag suppress, lane order, element size |
| addr_a | input | 64 | Address of the first element of the span |
| addr_b | input | 64 | Address of the last element of the span |
| narrow_mode | input | 1 | Use only the low 32 address bits for masks and block comparison |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_mask | output | 64 | Zero-extended lane mask |
| cc_narrow | output | 4 | Flags {N,Z,V,C} of the 32-bit subtraction |
| cc_wide | output | 4 | Flags {N,Z,V,C} of the 64-bit subtraction |

## Verification
One request can drive two functions in the same cycle: the mask lookup, which sees truncated addresses in 32-bit mode, and the flag update, which always sees the full addresses. The bench provokes this with a request in 32-bit mode whose addresses differ only in their upper halves, using a code that updates the flags. The mask must then follow the same-block rule, while `cc_wide` must carry the sign and borrow of the full 64-bit difference. The same address pair is then issued without 32-bit mode, and the mask must change to the left mask alone.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_ALT  = 2'b11
    } elem_sz_e;

    typedef struct packed {
        elem_sz_e size;
        logic     little;
        logic     no_flags;
    } op_t;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic borrow;
    } flags_t;

    function automatic op_t decode_op(input logic [3:0] code);
        op_t o;
        o.size     = elem_sz_e'(code[3:2]);
        o.little   = code[1];
        o.no_flags = code[0];
        return o;
    endfunction

endpackage

// File: rtl/edge_lane_masks.sv
module edge_lane_masks #(
    parameter int LANES  = 8,
    parameter int IDX_W  = 3,
    parameter int MASK_W = 8
) (
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [IDX_W-1:0]  idx_b,
    input  logic              little,
    output logic [MASK_W-1:0] left,
    output logic [MASK_W-1:0] right
);
    localparam logic [MASK_W-1:0] FULL = MASK_W'((1 << LANES) - 1);
    localparam logic [MASK_W-1:0] HEAD = FULL >> 1;
    localparam logic [MASK_W-1:0] TAIL = (FULL << 1) & FULL;

    always_comb begin
        if (little) begin
            left  = (FULL << idx_a) & FULL;
            right = ~((TAIL << idx_b) & FULL) & FULL;
        end else begin
            left  = FULL >> idx_a;
            right = ~(HEAD >> idx_b) & FULL;
        end
    end
endmodule

// File: rtl/edge_cc_calc.sv
module edge_cc_calc #(
    parameter int W = 64
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [3:0]   flags
);
    import edge_mask_pkg::*;

    logic [W-1:0] diff;
    flags_t       f;

    always_comb begin
        diff     = opa - opb;
        f.neg    = diff[W-1];
        f.zero   = (diff == '0);
        f.ovf    = (opa[W-1] ^ opb[W-1]) & (diff[W-1] ^ opa[W-1]);
        f.borrow = (opa < opb);
        flags    = f;
    end
endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit #(
    parameter int ADDR_W      = 64,
    parameter int HALF_W      = 32,
    parameter int BLOCK_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        edge_op,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              narrow_mode,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_mask,
    output logic [3:0]        cc_narrow,
    output logic [3:0]        cc_wide
);
    import edge_mask_pkg::*;

    localparam int OFS_W  = $clog2(BLOCK_BYTES);
    localparam int MASK_W = BLOCK_BYTES;
    localparam int NUM_SZ = 3;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] mask;
        logic [3:0]        cc_n;
        logic [3:0]        cc_w;
    } state_t;

    state_t st_d, st_q;
    op_t    op_dec;

    logic [ADDR_W-1:0] a_eff, b_eff;
    logic [MASK_W-1:0] left_m  [NUM_SZ];
    logic [MASK_W-1:0] right_m [NUM_SZ];
    logic [3:0]        flags_n, flags_w;

    assign op_dec = decode_op(edge_op);
    assign a_eff  = narrow_mode ? {{(ADDR_W-HALF_W){1'b0}}, addr_a[HALF_W-1:0]} : addr_a;
    assign b_eff  = narrow_mode ? {{(ADDR_W-HALF_W){1'b0}}, addr_b[HALF_W-1:0]} : addr_b;

    // One lane-mask generator per element size; size s has BLOCK_BYTES>>s lanes.
    for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
        localparam int LN = BLOCK_BYTES >> s;
        localparam int IW = $clog2(LN);
        edge_lane_masks #(
            .LANES  (LN),
            .IDX_W  (IW),
            .MASK_W (MASK_W)
        ) u_lm (
            .idx_a  (a_eff[OFS_W-1 -: IW]),
            .idx_b  (b_eff[OFS_W-1 -: IW]),
            .little (op_dec.little),
            .left   (left_m[s]),
            .right  (right_m[s])
        );
    end

    // Flags always use the untruncated addresses.
    edge_cc_calc #(.W(ADDR_W)) u_cc_w (
        .opa   (addr_a),
        .opb   (addr_b),
        .flags (flags_w)
    );

    edge_cc_calc #(.W(HALF_W)) u_cc_n (
        .opa   (addr_a[HALF_W-1:0]),
        .opb   (addr_b[HALF_W-1:0]),
        .flags (flags_n)
    );

    logic [1:0]        sel;
    logic [MASK_W-1:0] left_sel, right_sel, mask_new;
    logic              same_blk;

    always_comb begin
        unique case (op_dec.size)
            SZ_HALF: sel = 2'd1;
            SZ_WORD: sel = 2'd2;
            default: sel = 2'd0;
        endcase
        left_sel  = left_m[sel];
        right_sel = right_m[sel];
        same_blk  = (a_eff[ADDR_W-1:OFS_W] == b_eff[ADDR_W-1:OFS_W]);
        mask_new  = same_blk ? (left_sel & right_sel) : left_sel;

        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.mask = {{(ADDR_W-MASK_W){1'b0}}, mask_new};
            if (!op_dec.no_flags) begin
                st_d.cc_n = flags_n;
                st_d.cc_w = flags_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign res_mask  = st_q.mask;
    assign cc_narrow = st_q.cc_n;
    assign cc_wide   = st_q.cc_w;
endmodule

// File: rtl/edge_mask_chk.sv
module edge_mask_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        edge_op,
    input logic [ADDR_W-1:0] addr_a,
    input logic [ADDR_W-1:0] addr_b,
    input logic              narrow_mode,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_mask,
    input logic [3:0]        cc_narrow,
    input logic [3:0]        cc_wide
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(req_valid));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_mask[ADDR_W-1:8] == '0));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || edge_op[0]) |=> ($stable(cc_narrow) && $stable(cc_wide)));

    // R9
    equal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !edge_op[0] && (addr_a == addr_b))
        |=> (cc_wide == 4'b0100 && cc_narrow == 4'b0100));

    // R7
    left_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !narrow_mode && edge_op[3:1] == 3'b000
         && (addr_a[ADDR_W-1:3] != addr_b[ADDR_W-1:3]))
        |=> (res_mask[7:0] == (8'hFF >> $past(addr_a[2:0]))));
endmodule

bind edge_mask_unit edge_mask_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .edge_op     (edge_op),
    .addr_a      (addr_a),
    .addr_b      (addr_b),
    .narrow_mode (narrow_mode),
    .res_valid   (res_valid),
    .res_mask    (res_mask),
    .cc_narrow   (cc_narrow),
    .cc_wide     (cc_wide)
);

// File: tb/sim_edge_mask_unit.sv
module sim_edge_mask_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  edge_op = '0;
    logic [63:0] addr_a = '0;
    logic [63:0] addr_b = '0;
    logic        narrow_mode = 1'b0;
    logic        res_valid;
    logic [63:0] res_mask;
    logic [3:0]  cc_narrow, cc_wide;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    edge_mask_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .edge_op(edge_op),
        .addr_a(addr_a), .addr_b(addr_b), .narrow_mode(narrow_mode),
        .res_valid(res_valid), .res_mask(res_mask),
        .cc_narrow(cc_narrow), .cc_wide(cc_wide)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        nar;
        logic [63:0] a;
        logic [63:0] b;
        logic [7:0]  m;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 1'b0, 64'h1003, 64'h1005, 8'h1C},
        '{4'h0, 1'b0, 64'h1003, 64'h1010, 8'h1F},
        '{4'h2, 1'b0, 64'h2002, 64'h2006, 8'h7C},
        '{4'h4, 1'b0, 64'h0002, 64'h0006, 8'h07},
        '{4'h6, 1'b0, 64'h0004, 64'h0004, 8'h04},
        '{4'h8, 1'b0, 64'h0004, 64'h0000, 8'h00},
        '{4'hA, 1'b0, 64'h0000, 64'h0004, 8'h03},
        '{4'hA, 1'b0, 64'h0004, 64'h0008, 8'h02},
        '{4'h0, 1'b1, 64'hAAAA_0000_0000_1001, 64'h5555_0000_0000_1002, 8'h60},
        '{4'h0, 1'b0, 64'hAAAA_0000_0000_1001, 64'h5555_0000_0000_1002, 8'h7F},
        '{4'h1, 1'b0, 64'h1003, 64'h1005, 8'h1C},
        '{4'hC, 1'b0, 64'h0003, 64'h0005, 8'h1C},
        '{4'h5, 1'b0, 64'h0000, 64'h000E, 8'h0F},
        '{4'h3, 1'b0, 64'h0007, 64'hFF07, 8'h80}
    };

    localparam string VREQ [NV] = '{
        "R4 R7", "R4 R7", "R4 R7", "R5 R7", "R5 R7", "R6 R7", "R6 R7",
        "R6 R7", "R8", "R8", "R10", "R3", "R5 R10", "R4 R10"
    };

    function automatic logic [3:0] ref_flags64(input logic [63:0] a, input logic [63:0] b);
        logic signed [64:0] sd;
        logic        [64:0] ud;
        sd = $signed({a[63], a}) - $signed({b[63], b});
        ud = {1'b0, a} - {1'b0, b};
        return {sd[63], (a == b), (sd[64] != sd[63]), ud[64]};
    endfunction

    function automatic logic [3:0] ref_flags32(input logic [31:0] a, input logic [31:0] b);
        logic signed [32:0] sd;
        logic        [32:0] ud;
        sd = $signed({a[31], a}) - $signed({b[31], b});
        ud = {1'b0, a} - {1'b0, b};
        return {sd[31], (a == b), (sd[32] != sd[31]), ud[32]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic nar,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        edge_op     = op;
        narrow_mode = nar;
        addr_a      = a;
        addr_b      = b;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    logic [3:0] exp_n, exp_w;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check(res_valid == 1'b0 && res_mask == '0, "R1", {63'b0, res_valid} | res_mask, 64'h0);
        check(cc_narrow == 4'h0 && cc_wide == 4'h0, "R1", {56'b0, cc_narrow, cc_wide}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0 && res_mask == '0 && cc_wide == 4'h0, "R1",
              res_mask, 64'h0);

        exp_n = 4'h0;
        exp_w = 4'h0;
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].nar, VECS[i].a, VECS[i].b);
            if (!VECS[i].op[0]) begin
                exp_w = ref_flags64(VECS[i].a, VECS[i].b);
                exp_n = ref_flags32(VECS[i].a[31:0], VECS[i].b[31:0]);
            end
            // R2: result strobe and zero-extended mask one cycle after the request
            check(res_valid == 1'b1, "R2", {63'b0, res_valid}, 64'h1);
            check(res_mask == {56'b0, VECS[i].m}, VREQ[i], res_mask, {56'b0, VECS[i].m});
            // R9 / R10: flags updated or held
            check(cc_wide == exp_w && cc_narrow == exp_n,
                  VECS[i].op[0] ? "R10" : "R9",
                  {56'b0, cc_narrow, cc_wide}, {56'b0, exp_n, exp_w});
        end

        // R2: the strobe lasts a single cycle
        @(negedge clk);
        check(res_valid == 1'b0, "R2", {63'b0, res_valid}, 64'h0);

        // R9: signed overflow on 64 bits, borrow on 32 bits
        issue(4'h0, 1'b0, 64'h8000_0000_0000_0000, 64'h1);
        check(cc_wide == 4'b0010, "R9", {60'b0, cc_wide}, 64'h2);
        check(cc_narrow == 4'b1001, "R9", {60'b0, cc_narrow}, 64'h9);

        // R9: equal addresses set only Z
        issue(4'h4, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
        check(cc_wide == 4'b0100 && cc_narrow == 4'b0100, "R9",
              {56'b0, cc_narrow, cc_wide}, 64'h44);

        // R8 + R9: narrow mode masks truncated, flags from full values
        issue(4'h0, 1'b1, 64'h0000_0001_0000_0000, 64'h0000_0002_0000_0003);
        check(res_mask == 64'h0000_0000_0000_00F0, "R8", res_mask, 64'hF0);
        check(cc_wide == 4'b1001, "R9", {60'b0, cc_wide}, 64'h9);
        check(cc_narrow == 4'b1001, "R9", {60'b0, cc_narrow}, 64'h9);

        // R10: a no-flag code after that keeps the flags
        issue(4'h9, 1'b0, 64'h5, 64'h5);
        check(cc_wide == 4'b1001 && cc_narrow == 4'b1001, "R10",
              {56'b0, cc_narrow, cc_wide}, 64'h99);
        check(res_mask == 64'h1, "R6", res_mask, 64'h1);

        // R4: big-endian byte right mask fully set at offset 7, left at offset 0
        issue(4'h1, 1'b0, 64'h40, 64'h47);
        check(res_mask == 64'hFF, "R4", res_mask, 64'hFF);

        // R1: reset clears the registered state again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(res_mask == '0 && cc_wide == 4'h0 && cc_narrow == 4'h0, "R1",
              res_mask, 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule